// File: doc/BRIEF.md
# Register-Mapped Integer Square Root Unit

This block computes the unsigned integer square root of a radicand that software places in a register window. It has a 16-bit control word, a 64-bit radicand split over two 32-bit words, and a 32-bit result word. Bit 0 of the control word chooses the radicand width. When that bit is 0, only the low 32 bits of the radicand take part. When it is 1, all 64 bits take part.

Any write to the control word or to either radicand word launches a calculation. In the next cycle the result reads zero and bit 15 of the control word reads one. A restoring shift-subtract engine then produces one result bit per cycle: 16 cycles for a narrow radicand and 32 for a wide one. When the last bit is settled, the floor of the root is written to the result word and bit 15 drops. A launching write that arrives while a calculation runs abandons that calculation and starts a new one.

The controller has two states. IDLE waits for a launch; on a launch it goes to RUN. RUN stays in RUN while steps remain, and it restarts in RUN on a new launch. After the final step with no new launch, RUN returns to IDLE.

Top module: `sqrt_mmio_unit`

## Requirements
- R1: After reset, every mapped word reads zero and the busy flag (control bit 15) reads zero.
- R2: On the cycle after a write to offset 0x0 (control), 0x8 (radicand low) or 0xC (radicand high), the result word (offset 0x4) reads zero and control bit 15 reads one. Control bits 14..0 keep the value last written to them.
- R3: With control bit 0 equal to 0, the radicand is its low 32 bits; the high radicand word has no effect on the result.
- R4: With control bit 0 equal to 1, the radicand is the full 64-bit value, with offset 0xC holding bits 63..32.
- R5: When busy drops, the result word holds r, the largest value for which r*r does not exceed the radicand.
- R6: Busy stays high for exactly 16 cycles after the last launching write in narrow mode and exactly 32 cycles in wide mode. The result stays zero until busy drops.
- R7: A launching write while busy abandons the running calculation. The new calculation uses the new operands and takes its full latency from that write.
- R8: A zero radicand gives 0. A narrow all-ones radicand gives 0xFFFF. A wide all-ones radicand gives 0xFFFFFFFF.
- R9: Writes to the result offset and to unmapped offsets are ignored and launch nothing. Unmapped offsets read zero. Both radicand words read back as written. While idle, the result word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions watch every cycle for these properties. A launch always clears the result and raises busy in the next cycle. The result stays zero while busy. Every busy period ends after exactly 16 or 32 cycles, depending on the width bit. When busy falls, the result satisfies r*r <= radicand < (r+1)*(r+1). The idle result stays stable unless a launch occurs. The bench scenarios cover what the assertions cannot observe: which bus offsets map to which words, that an ignored high word truly leaves narrow results unchanged, the read-back of control bits, and the restart latency counted from an abandoning write.

// File: rtl/sqrt_mmio_pkg.sv
package sqrt_mmio_pkg;

    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CTRL_W    = 16;
    localparam int unsigned ROOT_W    = 32;
    localparam int unsigned RAD_W     = 2 * ROOT_W;
    localparam int unsigned CNT_W     = $clog2(ROOT_W + 1);
    localparam int unsigned BUSY_BIT  = CTRL_W - 1;
    localparam int unsigned WIDE_BIT  = 0;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RESULT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_RAD_LO = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RAD_HI = 4'hC;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } root_state_e;

endpackage

// File: rtl/sqrt_mmio_regs.sv
module sqrt_mmio_regs
    import sqrt_mmio_pkg::*;
#(
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_CTRL_W = CTRL_W,
    parameter int unsigned P_RAD_W  = RAD_W,
    parameter int unsigned P_ROOT_W = ROOT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [P_ADDR_W-1:0]  bus_addr,
    input  logic [P_DATA_W-1:0]  bus_wdata,
    input  logic                 busy,
    input  logic [P_ROOT_W-1:0]  result,
    output logic [P_DATA_W-1:0]  bus_rdata,
    output logic                 start,
    output logic                 next_wide,
    output logic [P_RAD_W-1:0]   next_param,
    output logic                 ctrl_wide,
    output logic [P_RAD_W-1:0]   param_q
);

    localparam int unsigned LOW_W = P_CTRL_W - 1;
    localparam int unsigned WORDS = P_RAD_W / P_DATA_W;

    logic [LOW_W-1:0] ctrl_low_q;
    logic [LOW_W-1:0] ctrl_low_d;
    logic [P_RAD_W-1:0] param_d;
    logic             wr_ctrl;
    logic             wr_lo;
    logic             wr_hi;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_lo   = bus_wr && (bus_addr == OFS_RAD_LO);
    assign wr_hi   = bus_wr && (bus_addr == OFS_RAD_HI);
    assign start   = wr_ctrl || wr_lo || wr_hi;

    always_comb begin
        ctrl_low_d = ctrl_low_q;
        if (wr_ctrl) begin
            ctrl_low_d = bus_wdata[LOW_W-1:0];
        end
    end

    always_comb begin
        param_d = param_q;
        if (wr_lo) begin
            param_d[P_DATA_W-1:0] = bus_wdata;
        end
        if (wr_hi) begin
            param_d[WORDS*P_DATA_W-1 -: P_DATA_W] = bus_wdata;
        end
    end

    assign next_param = param_d;
    assign next_wide  = ctrl_low_d[WIDE_BIT];
    assign ctrl_wide  = ctrl_low_q[WIDE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_low_q <= '0;
            param_q    <= '0;
        end else begin
            ctrl_low_q <= ctrl_low_d;
            param_q    <= param_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:   bus_rdata[P_CTRL_W-1:0] = {busy, ctrl_low_q};
            OFS_RESULT: bus_rdata[P_ROOT_W-1:0] = result;
            OFS_RAD_LO: bus_rdata = param_q[P_DATA_W-1:0];
            OFS_RAD_HI: bus_rdata = param_q[WORDS*P_DATA_W-1 -: P_DATA_W];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sqrt_mmio_fsm.sv
module sqrt_mmio_fsm
    import sqrt_mmio_pkg::*;
#(
    parameter int unsigned P_ROOT_W = ROOT_W,
    parameter int unsigned P_CNT_W  = CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic next_wide,
    output logic busy,
    output logic load,
    output logic step,
    output logic finish
);

    localparam logic [P_CNT_W-1:0] LAST_WIDE   = P_CNT_W'(P_ROOT_W - 1);
    localparam logic [P_CNT_W-1:0] LAST_NARROW = P_CNT_W'(P_ROOT_W / 2 - 1);

    root_state_e        state_q;
    root_state_e        state_d;
    logic [P_CNT_W-1:0] steps_left_q;
    logic               last_step;

    assign last_step = (steps_left_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)          state_d = ST_RUN;
                else if (last_step) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_left_q <= '0;
        end else if (start) begin
            steps_left_q <= next_wide ? LAST_WIDE : LAST_NARROW;
        end else if (state_q == ST_RUN && !last_step) begin
            steps_left_q <= steps_left_q - 1'b1;
        end
    end

    always_comb begin
        busy   = 1'b0;
        load   = start;
        step   = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy   = 1'b1;
                step   = !start;
                finish = !start && last_step;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sqrt_mmio_datapath.sv
module sqrt_mmio_datapath
    import sqrt_mmio_pkg::*;
#(
    parameter int unsigned P_ROOT_W = ROOT_W,
    parameter int unsigned P_RAD_W  = RAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                finish,
    input  logic                next_wide,
    input  logic [P_RAD_W-1:0]  next_param,
    output logic [P_ROOT_W-1:0] result_q
);

    localparam int unsigned REM_W   = P_ROOT_W + 2;
    localparam int unsigned TRIAL_W = P_ROOT_W + 4;
    localparam int unsigned HALF_W  = P_RAD_W / 2;

    logic [P_RAD_W-1:0]  rad_q;
    logic [REM_W-1:0]    rem_q;
    logic [P_ROOT_W-1:0] root_q;
    logic [TRIAL_W-1:0]  trial;
    logic [TRIAL_W-1:0]  divisor;
    logic                fits;
    logic [REM_W-1:0]    rem_d;
    logic [P_ROOT_W-1:0] root_d;
    logic [P_RAD_W-1:0]  rad_load;

    assign rad_load = next_wide ? next_param
                                : {next_param[HALF_W-1:0], {HALF_W{1'b0}}};

    assign trial   = {rem_q, rad_q[P_RAD_W-1 -: 2]};
    assign divisor = {2'b00, root_q, 2'b01};
    assign fits    = (trial >= divisor);

    always_comb begin
        if (fits) begin
            rem_d  = REM_W'(trial - divisor);
            root_d = {root_q[P_ROOT_W-2:0], 1'b1};
        end else begin
            rem_d  = trial[REM_W-1:0];
            root_d = {root_q[P_ROOT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (load) begin
            rad_q  <= rad_load;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step) begin
            rad_q  <= {rad_q[P_RAD_W-3:0], 2'b00};
            rem_q  <= rem_d;
            root_q <= root_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= '0;
        else if (load)   result_q <= '0;
        else if (finish) result_q <= root_d;
    end

endmodule

// File: rtl/sqrt_mmio_unit.sv
module sqrt_mmio_unit
    import sqrt_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic              start;
    logic              busy;
    logic              load;
    logic              step;
    logic              finish;
    logic              next_wide;
    logic              ctrl_wide;
    logic [RAD_W-1:0]  next_param;
    logic [RAD_W-1:0]  param_q;
    logic [ROOT_W-1:0] result_q;

    sqrt_mmio_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .result     (result_q),
        .bus_rdata  (bus_rdata),
        .start      (start),
        .next_wide  (next_wide),
        .next_param (next_param),
        .ctrl_wide  (ctrl_wide),
        .param_q    (param_q)
    );

    sqrt_mmio_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .next_wide (next_wide),
        .busy      (busy),
        .load      (load),
        .step      (step),
        .finish    (finish)
    );

    sqrt_mmio_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .finish     (finish),
        .next_wide  (next_wide),
        .next_param (next_param),
        .result_q   (result_q)
    );

endmodule

// File: rtl/sqrt_mmio_checker.sv
module sqrt_mmio_checker
    import sqrt_mmio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              wide,
    input logic [RAD_W-1:0]  param,
    input logic [ROOT_W-1:0] result_q
);

    localparam int unsigned EXT_W = RAD_W + 2;

    logic [7:0]       run_len;
    logic [EXT_W-1:0] rad_ext;
    logic [EXT_W-1:0] sq_lo;
    logic [EXT_W-1:0] sq_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= '0;
        else if (start) run_len <= '0;
        else if (busy)  run_len <= run_len + 1'b1;
    end

    assign rad_ext = wide ? EXT_W'(param) : EXT_W'(param[RAD_W/2-1:0]);
    assign sq_lo   = EXT_W'(result_q) * EXT_W'(result_q);
    assign sq_hi   = (EXT_W'(result_q) + 1'b1) * (EXT_W'(result_q) + 1'b1);

    a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && result_q == '0));

    a_r6_zero_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (result_q == '0));

    a_r6_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == (wide ? 8'd32 : 8'd16)));

    a_r5_floor_root: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sq_lo <= rad_ext && sq_hi > rad_ext));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result_q));

endmodule

bind sqrt_mmio_unit sqrt_mmio_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .wide     (ctrl_wide),
    .param    (param_q),
    .result_q (result_q)
);

// File: tb/sqrt_mmio_unit_bench.sv
module sqrt_mmio_unit_bench;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NVEC = 13;

    typedef struct packed {
        logic        wide;
        logic [63:0] rad;
        logic [31:0] root;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'h0000_0000_0000_0000, 32'h0000_0000},
        '{1'b0, 64'h0000_0000_0000_0001, 32'h0000_0001},
        '{1'b0, 64'h0000_0000_0000_0002, 32'h0000_0001},
        '{1'b0, 64'h0000_0000_0000_000F, 32'h0000_0003},
        '{1'b0, 64'h0000_0000_0000_0010, 32'h0000_0004},
        '{1'b0, 64'h0000_0000_FFFF_FFFF, 32'h0000_FFFF},
        '{1'b0, 64'hDEAD_BEEF_0000_0064, 32'h0000_000A},
        '{1'b1, 64'h0000_0001_0000_0000, 32'h0001_0000},
        '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF},
        '{1'b1, 64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF},
        '{1'b1, 64'hFFFF_FFFE_0000_0000, 32'hFFFF_FFFE},
        '{1'b1, 64'h0000_00E8_D4A5_1000, 32'h000F_4240},
        '{1'b1, 64'h0000_0000_0000_0003, 32'h0000_0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    sqrt_mmio_unit u_sqrt_mmio_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic [31:0] d;
        int unsigned n;
        n = v.wide ? 32 : 16;
        wr(4'h8, v.rad[31:0]);
        wr(4'hC, v.rad[63:32]);
        wr(4'h0, {31'b0, v.wide});
        rd(4'h0, d); chk({tag, " R2 busy set"}, {16'b0, d[15], 15'b0}, 32'h8000);
        rd(4'h4, d); chk({tag, " R2 result cleared"}, d, 32'h0);
        repeat (n - 1) @(negedge clk);
        rd(4'h0, d); chk({tag, " R6 busy before last"}, {31'b0, d[15]}, 32'h1);
        @(negedge clk);
        rd(4'h0, d); chk({tag, " R6 busy dropped"}, {31'b0, d[15]}, 32'h0);
        rd(4'h4, d); chk({tag, " R5 root"}, d, v.root);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
        rd(4'h4, d); chk("R1 result", d, 32'h0);
        rd(4'h8, d); chk("R1 rad lo", d, 32'h0);
        rd(4'hC, d); chk("R1 rad hi", d, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R8: vector table
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d R3/R4/R8", i));
        end

        // R9: radicand read-back, unmapped reads, ignored writes
        rd(4'h8, d); chk("R9 rad lo readback", d, 32'h0000_0003);
        rd(4'hC, d); chk("R9 rad hi readback", d, 32'h0000_0000);
        rd(4'h2, d); chk("R9 unmapped read", d, 32'h0);
        wr(4'h4, 32'h1234_5678);
        rd(4'h0, d); chk("R9 result write no launch", d, 32'h0001);
        rd(4'h4, d); chk("R9 result write ignored", d, 32'h0000_0001);
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R9 unmapped write no launch", d, 32'h0001);
        rd(4'h4, d); chk("R9 unmapped write ignored", d, 32'h0000_0001);

        // R2: control bits kept, param write keeps them
        wr(4'h0, 32'h0000_0ABC);
        rd(4'h0, d); chk("R2 ctrl while busy", d, 32'h0000_8ABC);
        wr(4'h8, 32'h0000_0019);
        rd(4'h0, d); chk("R2 ctrl kept on param write", d, 32'h0000_8ABC);
        repeat (16) @(negedge clk);
        rd(4'h0, d); chk("R2 ctrl after done", d, 32'h0000_0ABC);
        rd(4'h4, d); chk("R3 narrow root of 25", d, 32'h0000_0005);

        // R7: abort a wide run midway, restart narrow
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h0, 32'h0000_0001);
        repeat (10) @(negedge clk);
        wr(4'h8, 32'h0000_0051);
        wr(4'h0, 32'h0000_0000);
        rd(4'h4, d); chk("R7 result cleared on abort", d, 32'h0);
        repeat (15) @(negedge clk);
        rd(4'h0, d); chk("R7 still busy at 15", {31'b0, d[15]}, 32'h1);
        @(negedge clk);
        rd(4'h0, d); chk("R7 done at 16", {31'b0, d[15]}, 32'h0);
        rd(4'h4, d); chk("R7 new operand root", d, 32'h0000_0009);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule